// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block gathers up to sixteen level-sensitive interrupt lines into a single registered request that feeds a parent interrupt controller. Each line has an enable bit, which decides whether the line can latch a pending flag, and a mask bit, which decides whether a pending flag reaches the combined request. Pending flags stay latched until software acknowledges them by writing ones to the status register.

Software reaches the block over a simple synchronous register bus: a word address, a write strobe, 16-bit write data and 16-bit read data. The byte offsets of the registers are four apart, so the bus carries the byte offset shifted right by two. The enable bits and the mask bits each have a separate set address and a separate clear address. Any single bit can therefore be changed in one write, with no read-modify-write. In the mask register, a set bit means the line is unmasked, that is, it is allowed through to the request.

Top module: `irq_agg_top`

Word address map (byte offset / 4):

| Word | Read | Write |
|------|------|-------|
| 0 | pending flags | ones acknowledge (clear) those flags |
| 1 | enable | ones set enable bits |
| 2 | enable | ones clear enable bits |
| 3 | mask (1 = unmasked) | ones unmask |
| 4 | mask (1 = unmasked) | ones mask |
| other | 0 | ignored |

## Requirements
- R1: After reset, every enable bit, every mask bit and every pending flag is 0, and irq_out is 0.
- R2: A write to word 1 sets each enable bit whose data bit is 1. A write to word 2 clears each enable bit whose data bit is 1. Bits written as 0 keep their value.
- R3: A write to word 3 sets each mask bit whose data bit is 1 (unmask). A write to word 4 clears each mask bit whose data bit is 1 (mask). Bits written as 0 keep their value.
- R4: Pending bit i becomes 1 on the clock edge after a cycle in which src_in[i] is high and enable bit i is 1. It stays 1 while the source is idle. Bit i of the source drives pending bit i.
- R5: A write to word 0 clears each pending bit whose data bit is 1. If the source is still high and enabled after the acknowledge, the bit is set again on the following edge. Bits written as 0 keep their value.
- R6: A source whose enable bit is 0 never sets its pending bit.
- R7: irq_out is a register. It is 1 exactly one cycle after some bit of (pending AND mask) is nonzero.
- R8: A mask write to word 4 followed on the next cycle by an acknowledge of the same bit leaves that bit masked and not pending, and irq_out is 0.
- R9: Reading word 0 returns the pending flags. Reading word 1 or word 2 returns the enable register. Reading word 3 or word 4 returns the mask register. Any other word reads 0. rd_data is combinational from the address.
- R10: Writes to unused words change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 16 | Level-sensitive interrupt sources |
| addr | input | 3 | Word address (byte offset / 4) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr |
| irq_out | output | 1 | Combined registered request |

## Verification
The bench writes patterns with zeros mixed between ones. A design that treated the set and clear words as plain loads would wipe the untouched bits. It acknowledges a line whose source is still high, so a design that failed to set the flag again would lose a level interrupt. It also holds a disabled source high and checks that no flag appears. The mask-then-acknowledge sequence catches a design that lets the acknowledge undo the mask. Reads of both the set and the clear alias, and writes to unused words, expose faults in address decoding.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_STAT   = 3'd0,
    A_EN_SET = 3'd1,
    A_EN_CLR = 3'd2,
    A_MK_SET = 3'd3,
    A_MK_CLR = 3'd4
  } reg_addr_e;

  function automatic logic [15:0] w1s_w1c(input logic [15:0] cur,
      input logic [15:0] set_v, input logic [15:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      mk_q,
  output logic [N-1:0]      ack_v
);
  logic [N-1:0] en_set, en_clr, mk_set, mk_clr;

  always_comb begin
    en_set = '0; en_clr = '0; mk_set = '0; mk_clr = '0; ack_v = '0;
    if (wr_en) begin
      case (addr)
        A_STAT:   ack_v  = wr_data;
        A_EN_SET: en_set = wr_data;
        A_EN_CLR: en_clr = wr_data;
        A_MK_SET: mk_set = wr_data;
        A_MK_CLR: mk_clr = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      mk_q <= '0;
    end else begin
      en_q <= w1s_w1c(en_q, en_set, en_clr);
      mk_q <= w1s_w1c(mk_q, mk_set, mk_clr);
    end
  end

  AST_EN_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set == '0 && en_clr == '0) |=> $stable(en_q)); // R2
  AST_MK_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_clr != '0) |=> ((mk_q & $past(mk_clr)) == '0)); // R3
  AST_UNUSED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > A_MK_CLR) |=> ($stable(en_q) && $stable(mk_q))); // R10
endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] en_q,
  input  logic [N-1:0] ack_v,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] latch_ev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign latch_ev[i] = src_in[i] & en_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n)          pend_q[i] <= 1'b0;
      else if (ack_v[i])   pend_q[i] <= 1'b0;
      else if (latch_ev[i]) pend_q[i] <= 1'b1;
    end
  end

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (pend_q & ~$past(pend_q) & ~$past(en_q)) != '0) |-> 1'b0); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_v != '0) |=> ((pend_q & $past(ack_v)) == '0)); // R5
  AST_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_ev != '0 && ack_v == '0) |=> ((pend_q & $past(latch_ev)) == $past(latch_ev))); // R4
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      rd_data,
  output logic              irq_out
);
  logic [N-1:0] en_q, mk_q, ack_v, pend_q;
  logic         any_live;

  irq_agg_regs #(.N(N)) u_regs (
    .clk, .rst_n, .addr, .wr_en, .wr_data,
    .en_q, .mk_q, .ack_v
  );

  irq_agg_pend #(.N(N)) u_pend (
    .clk, .rst_n, .src_in, .en_q, .ack_v, .pend_q
  );

  assign any_live = |(pend_q & mk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= any_live;
  end

  always_comb begin
    case (addr)
      A_STAT:             rd_data = pend_q;
      A_EN_SET, A_EN_CLR: rd_data = en_q;
      A_MK_SET, A_MK_CLR: rd_data = mk_q;
      default:            rd_data = '0;
    endcase
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_out == $past(any_live))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (!irq_out && pend_q == '0 && mk_q == '0 && en_q == '0)); // R1
endmodule

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] src_in = '0;
  logic [2:0]  addr = '0;
  logic        wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_out;
  int          n_run = 0, n_fail = 0;

  irq_agg_top dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #0.5 d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 0; src_in = '0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(0, v); chk("R1 pend", v, 16'h0);
    rd(1, v); chk("R1 en", v, 16'h0);
    rd(3, v); chk("R1 mask", v, 16'h0);
    chk("R1 irq", {15'b0, irq_out}, 16'h0);
  endtask

  task automatic t_setclr();
    logic [15:0] v;
    do_reset();
    wr(1, 16'hA5A5); wr(1, 16'h0102);
    rd(2, v); chk("R2 en set", v, 16'hA5A7);
    wr(2, 16'h0021);
    rd(1, v); chk("R2 en clr", v, 16'hA586);
    wr(3, 16'hF00F); wr(4, 16'h1001);
    rd(4, v); chk("R3 mask", v, 16'hE00E);
    rd(3, v); chk("R9 alias", v, 16'hE00E);
    wr(5, 16'hFFFF); wr(7, 16'hFFFF);
    rd(1, v); chk("R10 en", v, 16'hA586);
    rd(3, v); chk("R10 mask", v, 16'hE00E);
    rd(6, v); chk("R9 unused", v, 16'h0);
  endtask

  task automatic t_pend();
    logic [15:0] v;
    do_reset();
    wr(1, 16'h00FF);
    @(negedge clk); src_in = 16'h0301;
    @(negedge clk); src_in = '0;
    rd(0, v); chk("R4/R6 pend", v, 16'h0001);
    chk("R7 masked irq", {15'b0, irq_out}, 16'h0);
    wr(3, 16'h0001);
    @(negedge clk); chk("R7 irq", {15'b0, irq_out}, 16'h1);
    wr(0, 16'h0001);
    rd(0, v); chk("R5 ack", v, 16'h0);
    @(negedge clk); chk("R7 irq drop", {15'b0, irq_out}, 16'h0);
    src_in = 16'h0004;
    @(negedge clk); wr(0, 16'h0004);
    rd(0, v); chk("R5 reassert", v, 16'h0004);
    src_in = '0;
    wr(0, 16'h0000);
    rd(0, v); chk("R5 zero ack", v, 16'h0004);
  endtask

  task automatic t_mask_ack();
    logic [15:0] v;
    do_reset();
    wr(1, 16'hFFFF); wr(3, 16'h0010);
    @(negedge clk); src_in = 16'h0010;
    @(negedge clk); src_in = '0;
    @(negedge clk); chk("R7 on", {15'b0, irq_out}, 16'h1);
    wr(4, 16'h0010); wr(0, 16'h0010);
    rd(0, v); chk("R8 pend", v, 16'h0);
    rd(3, v); chk("R8 mask", v, 16'h0);
    @(negedge clk); chk("R8 irq", {15'b0, irq_out}, 16'h0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_setclr(); t_pend(); t_mask_ack();
      end
      begin
        repeat (20000) @(posedge clk);
        n_fail++; n_run++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule